// File: doc/BRIEF.md
# ETU Time-Out Counter Block

This block measures time-outs on a smart-card serial line in units of elementary time units (ETUs). It holds three 8-bit counter stages. A mode byte written by the host decides how the stages are used. They can run as an independent 8-bit auto-reload counter plus a 16-bit one-shot counter, or chain into one 24-bit one-shot counter. A 16-bit counter can also be retriggered by every START bit seen on the line. Each stage decrements once per qualified ETU tick. When a counter reaches its terminal count, a sticky flag is raised and the interrupt output follows.

The ETU tick and the START-bit strobe come from neighbouring logic as single-cycle pulses. The host loads the reload bytes and the mode byte through a plain write port. It clears the flags with a two-bit clear strobe. There is no data stream at this block's edge, so every pin is plain control or status. No back-pressure applies.

Top module: `etu_timeout`

## Requirements
- R1: After reset, all reload bytes and the mode byte are zero, every counter is idle, and `flag_short`, `flag_long` and `irq` are low.
- R2: A write with `wr_addr` 0, 1 or 2 loads reload bits 7:0, 15:8 or 23:16 respectively. A write with `wr_addr` 3 loads the mode byte. The 16-bit counter uses bits 23:8, and the 8-bit counter uses bits 7:0.
- R3: A tick counts only when `etu_tick` and `card_active` are both high. A counter loaded with L ≥ 1 reaches terminal count on the L-th counted tick. A load of 0 reaches terminal count on the first counted tick.
- R4: Mode 8'h00 and every code not listed in R5–R9 stop all counters. No flag is raised afterwards.
- R5: Mode 8'h61 loads the 16-bit counter on the write and starts it. At terminal count it sets `flag_long` once and stops. The 8-bit counter stays idle.
- R6: Mode 8'h65 starts the 16-bit counter as in R5 and arms the 8-bit counter. The 8-bit counter loads on the first `start_bit` after the write. It sets `flag_short` at every terminal count and reloads itself. Later `start_bit` pulses do not restart it.
- R7: Mode 8'h05 stops the 16-bit counter. The 8-bit counter keeps its state and keeps auto-reloading.
- R8: Mode 8'h68 loads all 24 reload bits into one chained counter on the write. At terminal count it sets `flag_long` once and stops.
- R9: In mode 8'h71, every `start_bit` reloads and restarts the 16-bit counter, which sets `flag_long` at terminal count. A reload byte written during a count takes effect only at the next `start_bit`.
- R10: Both flags are sticky. `flag_clr[0]` clears `flag_short` and `flag_clr[1]` clears `flag_long`. A set in the same cycle wins over the clear. `irq` is high whenever either flag is high.
- R11: In a cycle with a mode write, `etu_tick` and `start_bit` are ignored. A `start_bit` reload takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Write target: 0..2 reload bytes, 3 mode |
| wr_data | input | W | Write data |
| etu_tick | input | 1 | One-cycle pulse per ETU |
| start_bit | input | 1 | One-cycle pulse on a detected START bit |
| card_active | input | 1 | Counting enable while a card is powered and clocked |
| flag_clr | input | 2 | Clear strobes: bit 0 short flag, bit 1 long flag |
| flag_short | output | 1 | Sticky terminal flag of the 8-bit counter |
| flag_long | output | 1 | Sticky terminal flag of the 16-bit or 24-bit counter |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check three properties on every cycle. Neither flag can rise without a counted tick in the previous cycle. The flags stay set until their clear bit is asserted. The stopped and 16-bit-only modes never raise the flag of the idle counter. The exact terminal cycle depends on the reload value, on auto-reload and on START-bit retriggering. So does the deferred effect of a reload written mid-count. The bench's scenarios show these, with a behavioural model compared every clock and directed checks at the predicted tick counts.

// File: rtl/etu_tmo_pkg.sv
package etu_tmo_pkg;
  localparam int NSTG = 3;
  localparam logic [1:0] ADDR_MODE = 2'd3;
  localparam logic [7:0] MODE_OFF      = 8'h00;
  localparam logic [7:0] MODE_HOLD16   = 8'h05;
  localparam logic [7:0] MODE_ONE16    = 8'h61;
  localparam logic [7:0] MODE_DUAL     = 8'h65;
  localparam logic [7:0] MODE_CHAIN24  = 8'h68;
  localparam logic [7:0] MODE_RETRIG16 = 8'h71;
endpackage

// File: rtl/etu_tmo_regs.sv
module etu_tmo_regs
  import etu_tmo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [W-1:0]             wr_data,
  output logic [NSTG-1:0][W-1:0]   rld,
  output logic [7:0]               mode_q
);
  for (genvar k = 0; k < NSTG; k++) begin : g_rld
    always_ff @(posedge clk) begin
      if (!rst_n) rld[k] <= '0;
      else if (wr_en && wr_addr == 2'(k)) rld[k] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else if (wr_en && wr_addr == ADDR_MODE) mode_q <= wr_data[7:0];
  end
endmodule

// File: rtl/etu_tmo_stage.sv
module etu_tmo_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/etu_tmo_flags.sv
module etu_tmo_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set,
  input  logic [1:0] clr,
  output logic [1:0] flags,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
  assign irq = |flags;
endmodule

// File: rtl/etu_timeout.sv
module etu_timeout
  import etu_tmo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         etu_tick,
  input  logic         start_bit,
  input  logic         card_active,
  input  logic [1:0]   flag_clr,
  output logic         flag_short,
  output logic         flag_long,
  output logic         irq
);
  localparam int CW16 = 2 * W;
  localparam int CW24 = NSTG * W;

  logic [NSTG-1:0][W-1:0] rld, cnt, lval;
  logic [NSTG-1:0]        ld, dec;
  logic [7:0]             mode_q;
  logic                   cfg_wr, adv, stb;
  logic                   run1, arm1, run16, arm16, run24;
  logic                   term1, term16, term24, restart16;
  logic [1:0]             fl;

  etu_tmo_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rld(rld), .mode_q(mode_q)
  );

  assign cfg_wr    = wr_en && (wr_addr == ADDR_MODE);
  assign adv       = etu_tick && card_active && !cfg_wr;
  assign stb       = start_bit && !cfg_wr;
  assign restart16 = arm16 && stb;

  assign term1  = run1 && adv && (cnt[0] <= W'(1));
  assign term16 = run16 && adv && !restart16 &&
                  ({cnt[2], cnt[1]} <= CW16'(1));
  assign term24 = run24 && adv && (CW24'(cnt) <= CW24'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {run1, arm1, run16, arm16, run24} <= '0;
    end else if (cfg_wr) begin
      case (wr_data[7:0])
        MODE_HOLD16: begin
          run16 <= 1'b0; arm16 <= 1'b0; run24 <= 1'b0;
        end
        MODE_ONE16: begin
          run1 <= 1'b0; arm1 <= 1'b0; run16 <= 1'b1; arm16 <= 1'b0; run24 <= 1'b0;
        end
        MODE_DUAL: begin
          run1 <= 1'b0; arm1 <= 1'b1; run16 <= 1'b1; arm16 <= 1'b0; run24 <= 1'b0;
        end
        MODE_CHAIN24: begin
          run1 <= 1'b0; arm1 <= 1'b0; run16 <= 1'b0; arm16 <= 1'b0; run24 <= 1'b1;
        end
        MODE_RETRIG16: begin
          run1 <= 1'b0; arm1 <= 1'b0; run16 <= 1'b0; arm16 <= 1'b1; run24 <= 1'b0;
        end
        default: {run1, arm1, run16, arm16, run24} <= '0;
      endcase
    end else begin
      if (arm1 && stb) begin
        run1 <= 1'b1;
        arm1 <= 1'b0;
      end
      if (restart16)   run16 <= 1'b1;
      else if (term16) run16 <= 1'b0;
      if (term24)      run24 <= 1'b0;
    end
  end

  // load selection and borrow chain
  always_comb begin
    ld   = '0;
    lval = '0;
    if (cfg_wr) begin
      if (wr_data[7:0] == MODE_CHAIN24) begin
        ld   = '1;
        lval = rld;
      end else if (wr_data[7:0] == MODE_ONE16 || wr_data[7:0] == MODE_DUAL) begin
        ld[2:1]   = 2'b11;
        lval[2:1] = rld[2:1];
      end
    end else begin
      if ((arm1 && stb) || term1) begin
        ld[0]   = 1'b1;
        lval[0] = rld[0];
      end else if (term24) begin
        ld[0] = 1'b1;
      end
      if (restart16) begin
        ld[2:1]   = 2'b11;
        lval[2:1] = rld[2:1];
      end else if (term16 || term24) begin
        ld[2:1] = 2'b11;
      end
    end
    dec[0] = (run1 || run24) && adv;
    dec[1] = (run16 && adv) || (run24 && dec[0] && cnt[0] == '0);
    dec[2] = dec[1] && cnt[1] == '0;
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    etu_tmo_stage #(.W(W)) u_stg (
      .clk(clk), .rst_n(rst_n), .load(ld[k]), .load_val(lval[k]),
      .dec(dec[k]), .cnt(cnt[k])
    );
  end

  etu_tmo_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set({term16 || term24, term1}),
    .clr(flag_clr), .flags(fl), .irq(irq)
  );

  assign flag_short = fl[0];
  assign flag_long  = fl[1];
endmodule

// File: rtl/etu_timeout_chk.sv
module etu_timeout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       etu_tick,
  input logic       card_active,
  input logic [1:0] flag_clr,
  input logic       flag_short,
  input logic       flag_long,
  input logic [7:0] mode_q
);
  a_r3_short_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_short && !(etu_tick && card_active)) |=> !flag_short);

  a_r3_long_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_long && !(etu_tick && card_active)) |=> !flag_long);

  a_r10_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_short && !flag_clr[0]) |=> flag_short);

  a_r10_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_long && !flag_clr[1]) |=> flag_long);

  a_r10_short_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_short && flag_clr[0] && !etu_tick) |=> !flag_short);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 8'h00 && !flag_short && !flag_long) |=> (!flag_short && !flag_long));

  a_r5_one16_no_short: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 8'h61 && !flag_short) |=> !flag_short);
endmodule

bind etu_timeout etu_timeout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .card_active(card_active),
  .flag_clr(flag_clr), .flag_short(flag_short), .flag_long(flag_long),
  .mode_q(mode_q)
);

// File: tb/etu_timeout_tb.sv
module etu_timeout_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       etu_tick = 1'b0, start_bit = 1'b0, card_active = 1'b1;
  logic [1:0] flag_clr = '0;
  logic       flag_short, flag_long, irq;

  int checks = 0, errors = 0;
  string cur = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  etu_timeout #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .etu_tick(etu_tick), .start_bit(start_bit), .card_active(card_active),
    .flag_clr(flag_clr), .flag_short(flag_short), .flag_long(flag_long), .irq(irq)
  );

  // behavioural reference model
  int m_lo, m_mid, m_hi, m_c1, m_c16, m_c24;
  bit m_r1, m_a1, m_r16, m_a16, m_r24, m_f1, m_f3;
  bit m_cw, m_adv, m_stb, m_s1, m_s3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_mid = 0; m_hi = 0; m_c1 = 0; m_c16 = 0; m_c24 = 0;
      m_r1 = 0; m_a1 = 0; m_r16 = 0; m_a16 = 0; m_r24 = 0; m_f1 = 0; m_f3 = 0;
    end else begin
      m_cw  = wr_en && wr_addr == 2'd3;
      m_adv = etu_tick && card_active && !m_cw;
      m_stb = start_bit && !m_cw;
      m_s1 = 0; m_s3 = 0;
      if (m_cw) begin
        case (wr_data)
          8'h05: begin m_r16 = 0; m_a16 = 0; m_r24 = 0; end
          8'h61: begin m_r1 = 0; m_a1 = 0; m_r16 = 1; m_a16 = 0; m_r24 = 0;
                       m_c16 = m_hi * 256 + m_mid; end
          8'h65: begin m_r1 = 0; m_a1 = 1; m_r16 = 1; m_a16 = 0; m_r24 = 0;
                       m_c16 = m_hi * 256 + m_mid; end
          8'h68: begin m_r1 = 0; m_a1 = 0; m_r16 = 0; m_a16 = 0; m_r24 = 1;
                       m_c24 = m_hi * 65536 + m_mid * 256 + m_lo; end
          8'h71: begin m_r1 = 0; m_a1 = 0; m_r16 = 0; m_a16 = 1; m_r24 = 0; end
          default: begin m_r1 = 0; m_a1 = 0; m_r16 = 0; m_a16 = 0; m_r24 = 0; end
        endcase
      end else begin
        if (m_a1 && m_stb) begin m_c1 = m_lo; m_r1 = 1; m_a1 = 0; end
        else if (m_r1 && m_adv) begin
          if (m_c1 <= 1) begin m_s1 = 1; m_c1 = m_lo; end else m_c1--;
        end
        if (m_a16 && m_stb) begin m_c16 = m_hi * 256 + m_mid; m_r16 = 1; end
        else if (m_r16 && m_adv) begin
          if (m_c16 <= 1) begin m_s3 = 1; m_r16 = 0; end else m_c16--;
        end
        if (m_r24 && m_adv) begin
          if (m_c24 <= 1) begin m_s3 = 1; m_r24 = 0; end else m_c24--;
        end
      end
      m_f1 = (m_f1 && !flag_clr[0]) || m_s1;
      m_f3 = (m_f3 && !flag_clr[1]) || m_s3;
      if (wr_en && wr_addr == 2'd0) m_lo  = int'(wr_data);
      if (wr_en && wr_addr == 2'd1) m_mid = int'(wr_data);
      if (wr_en && wr_addr == 2'd2) m_hi  = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (flag_short !== m_f1 || flag_long !== m_f3 || irq !== (m_f1 | m_f3)) begin
        errors++;
        $display("FAIL %s model: short/long/irq got %b%b%b exp %b%b%b", cur,
                 flag_short, flag_long, irq, m_f1, m_f3, m_f1 | m_f3);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b exp %b", what, got, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic s);
    etu_tick = t; start_bit = s;
    @(negedge clk);
    etu_tick = 1'b0; start_bit = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic t);
    wr_en = 1'b1; wr_addr = a; wr_data = d; etu_tick = t;
    @(negedge clk);
    wr_en = 1'b0; etu_tick = 1'b0;
  endtask

  task automatic clr(input logic [1:0] b);
    flag_clr = b;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur = "R1";
    chk(flag_short, 1'b0, "R1 short after reset");
    chk(flag_long, 1'b0, "R1 long after reset");
    chk(irq, 1'b0, "R1 irq after reset");
    ticks(3);
    chk(irq, 1'b0, "R1 idle after reset ticks");

    // R5 one-shot 16-bit, length 5
    cur = "R5";
    wr(2'd1, 8'd5, 1'b0); wr(2'd2, 8'd0, 1'b0); wr(2'd3, 8'h61, 1'b0);
    ticks(4);
    chk(flag_long, 1'b0, "R5 long before 5th tick");
    ticks(1);
    chk(flag_long, 1'b1, "R5 long at 5th tick");
    chk(irq, 1'b1, "R10 irq follows long");
    ticks(7);
    chk(flag_short, 1'b0, "R5 short stays idle");
    clr(2'b10);
    ticks(6);
    chk(flag_long, 1'b0, "R5 one shot, no second flag");

    // R3 card inactive gates ticks
    cur = "R3";
    wr(2'd1, 8'd3, 1'b0); wr(2'd3, 8'h61, 1'b0);
    card_active = 1'b0;
    ticks(5);
    chk(flag_long, 1'b0, "R3 ticks ignored while card inactive");
    card_active = 1'b1;
    ticks(2);
    chk(flag_long, 1'b0, "R3 long before 3rd counted tick");
    ticks(1);
    chk(flag_long, 1'b1, "R3 long at 3rd counted tick");
    clr(2'b10);
    chk(irq, 1'b0, "R10 clear drops irq");

    // R11 mode write with tick, zero load
    cur = "R11";
    wr(2'd1, 8'd0, 1'b0);
    wr(2'd3, 8'h61, 1'b1);
    chk(flag_long, 1'b0, "R11 tick in mode-write cycle ignored");
    ticks(1);
    chk(flag_long, 1'b1, "R3 zero load ends at first tick");
    clr(2'b10);

    // R2 high byte position: 256 ticks
    cur = "R2";
    wr(2'd0, 8'd0, 1'b0); wr(2'd1, 8'd0, 1'b0); wr(2'd2, 8'd1, 1'b0);
    wr(2'd3, 8'h61, 1'b0);
    ticks(255);
    chk(flag_long, 1'b0, "R2 long before 256th tick");
    ticks(1);
    chk(flag_long, 1'b1, "R2 long at 256th tick");
    clr(2'b10);

    // R8 24-bit chain, 0x000102 = 258
    cur = "R8";
    wr(2'd0, 8'd2, 1'b0); wr(2'd1, 8'd1, 1'b0); wr(2'd2, 8'd0, 1'b0);
    wr(2'd3, 8'h68, 1'b0);
    ticks(257);
    chk(flag_long, 1'b0, "R8 long before 258th tick");
    ticks(1);
    chk(flag_long, 1'b1, "R8 long at 258th tick");
    chk(flag_short, 1'b0, "R8 short unused");
    clr(2'b10);

    // R6 dual mode
    cur = "R6";
    wr(2'd0, 8'd3, 1'b0); wr(2'd1, 8'd10, 1'b0); wr(2'd2, 8'd0, 1'b0);
    wr(2'd3, 8'h65, 1'b0);
    ticks(5);
    chk(flag_short, 1'b0, "R6 8-bit waits for START");
    cyc(1'b0, 1'b1);
    ticks(2);
    chk(flag_short, 1'b0, "R6 short before 3rd tick");
    ticks(1);
    chk(flag_short, 1'b1, "R6 short at 3rd tick");
    clr(2'b01);
    cyc(1'b1, 1'b1);
    ticks(1);
    chk(flag_long, 1'b1, "R6 long at 10th tick after write");
    ticks(1);
    chk(flag_short, 1'b1, "R6 auto-reload, later START ignored");
    clr(2'b11);

    // R7 hold16 keeps 8-bit counter
    cur = "R7";
    wr(2'd0, 8'd2, 1'b0); wr(2'd1, 8'd20, 1'b0);
    wr(2'd3, 8'h65, 1'b0);
    cyc(1'b0, 1'b1);
    ticks(5);
    wr(2'd3, 8'h05, 1'b0);
    clr(2'b11);
    ticks(30);
    chk(flag_long, 1'b0, "R7 16-bit stopped");
    chk(flag_short, 1'b1, "R7 8-bit still reloading");

    // R4 stop and undefined code
    cur = "R4";
    wr(2'd3, 8'h00, 1'b0);
    clr(2'b11);
    ticks(10);
    chk(irq, 1'b0, "R4 mode 00 stops all");
    wr(2'd0, 8'd5, 1'b0); wr(2'd1, 8'd0, 1'b0);
    wr(2'd3, 8'h68, 1'b0);
    ticks(2);
    wr(2'd3, 8'h42, 1'b0);
    ticks(10);
    chk(flag_long, 1'b0, "R4 undefined code stops chain");
    chk(flag_short, 1'b0, "R4 undefined code short idle");

    // R9 retrigger
    cur = "R9";
    wr(2'd1, 8'd4, 1'b0); wr(2'd2, 8'd0, 1'b0);
    wr(2'd3, 8'h71, 1'b0);
    ticks(6);
    chk(flag_long, 1'b0, "R9 waits for START");
    cyc(1'b0, 1'b1);
    ticks(2);
    cyc(1'b0, 1'b1);
    wr(2'd1, 8'd8, 1'b0);
    ticks(3);
    chk(flag_long, 1'b0, "R9 restart pushes terminal");
    ticks(1);
    chk(flag_long, 1'b1, "R9 old value kept for current count");
    clr(2'b10);
    cyc(1'b0, 1'b1);
    ticks(7);
    chk(flag_long, 1'b0, "R9 new value before 8th tick");
    ticks(1);
    chk(flag_long, 1'b1, "R9 new value used at next START");
    clr(2'b10);

    // R10 set wins over clear
    cur = "R10";
    cyc(1'b0, 1'b1);
    ticks(7);
    flag_clr = 2'b10;
    cyc(1'b1, 1'b0);
    flag_clr = 2'b00;
    chk(flag_long, 1'b1, "R10 set beats clear");

    @(negedge clk);
    finish_run();
  end
endmodule